// File: doc/BRIEF.md
# Threshold Monitor Setup Loader

This block takes the byte stream that a serial host writes to set up a multi-channel threshold monitor, and it loads the contents into registers. A frame-start strobe begins each frame. The first byte of a frame is the setup byte. It holds one alarm-clear request per channel, a 3-bit scan-delay code and an interrupt enable. After the setup byte, each active channel receives three bytes. Together these bytes form a 12-bit lower bound and a 12-bit upper bound.

Two values decide which channels are active: the channel-select value and the differential-mode flag. Both are captured when the setup byte arrives. Skipped channels take no bytes, and the host sends no filler for them. In differential mode, one triple of bytes programs an even channel and the odd channel next to it together. Bytes that arrive after the last active channel are dropped, and a flag records that they arrived. Serial bus framing and acknowledge handling are done elsewhere.

Top module: `mon_setup_loader`

## Requirements
- R1: After reset, these outputs are all zero: `delay_code_o`, `int_en_o`, `alarm_clr_o`, `thr_we_o` and `overrun_o`. Every channel's lower bound is 0x000 and every channel's upper bound is 0xFFF.
- R2: The setup byte maps as follows. Bits [3:1] become `delay_code_o` and bit [0] becomes `int_en_o`. Both outputs change on the clock edge after the byte is accepted, and they hold their values until the next setup byte.
- R3: Bit 7-i of the setup byte requests an alarm clear for channel i. Each requested channel's bit of `alarm_clr_o` is high for exactly one cycle, on the cycle after the setup byte.
- R4: Each channel's three bytes carry the lower bound MSB first and then the upper bound MSB first. Byte 0 is lower[11:4]. Byte 1 is {lower[3:0], upper[11:8]}. Byte 2 is upper[7:0].
- R5: A channel's two bounds update together only on the clock edge that accepts its third byte. On that same edge, the channel's bit of `thr_we_o` goes high for one cycle. The first and second bytes raise no strobe.
- R6: In single-ended mode, channels 0 up to the captured select value receive data, in ascending order. The select value is captured together with the setup byte. A later change on `chan_sel_i` has no effect until the next setup byte.
- R7: In differential mode, only even channels up to the select value are visited. Each triple writes the even channel and the odd channel above it with the same bounds, with both strobe bits high.
- R8: A frame-start strobe on its own does three things: it discards any partially assembled triple, it clears `overrun_o`, and it makes the next byte the setup byte.
- R9: A byte that arrives after the last active channel changes no register and raises no strobe. It sets `overrun_o`, which stays high until the next frame start.
- R10: A byte that arrives in the same cycle as a frame-start strobe is taken as the setup byte of the new frame. This holds even when the byte arrives in the middle of a threshold triple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle strobe that marks the start of a new frame |
| byte_valid_i | input | 1 | `byte_data_i` holds a received byte |
| byte_data_i | input | 8 | Received byte |
| chan_sel_i | input | 2 | Highest channel to program (captured with the setup byte) |
| diff_mode_i | input | 1 | Differential pairing (captured with the setup byte) |
| delay_code_o | output | 3 | Scan-delay code |
| int_en_o | output | 1 | Interrupt enable |
| alarm_clr_o | output | 4 | One-cycle alarm-clear pulse for each channel |
| lo_thr_o | output | 48 | Lower bounds; channel i is at [12i+11:12i] |
| hi_thr_o | output | 48 | Upper bounds; channel i is at [12i+11:12i] |
| thr_we_o | output | 4 | One-cycle write strobe for each channel |
| overrun_o | output | 1 | Sticky flag for surplus bytes |

## Verification
The bench targets the alignment of the three-byte word. If a loader sent a strobe early, or swapped the nibbles of the middle byte, the bounds it loaded would be wrong, or a strobe would show up after byte 0 or byte 1. The bench also aborts a frame partway through a triple and then sends a triple whose values do not match the residue of the aborted one. A loader that kept the stale bytes would program shifted bounds.

Further tests cover the end of the channel list, in both modes and with several select values. Two faults show up there: a wrong stop point either gives up a channel or writes the surplus byte into a channel beyond the selection. Differential mode must produce a two-bit strobe on adjacent channels.

Finally, the bench sends a frame start together with a byte in the middle of a triple. A loader that gave the old frame priority would take that byte as threshold data and leave the delay code as it was.

// File: rtl/mon_setup_pkg.sv
package mon_setup_pkg;
  typedef enum logic [1:0] {
    ST_SETUP = 2'd0,
    ST_THR   = 2'd1,
    ST_DONE  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/mon_setup_decode.sv
module mon_setup_decode #(
  parameter int NUM_CH  = 4,
  parameter int BYTE_W  = 8,
  parameter int DELAY_W = 3
) (
  input  logic [BYTE_W-1:0]  byte_i,
  output logic [NUM_CH-1:0]  clr_mask_o,
  output logic [DELAY_W-1:0] delay_o,
  output logic               int_en_o
);
  // channel 0 sits in the MSB, higher channels follow downwards
  for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
    assign clr_mask_o[i] = byte_i[BYTE_W-1-i];
  end
  assign delay_o  = byte_i[DELAY_W:1];
  assign int_en_o = byte_i[0];
endmodule

// File: rtl/mon_chan_seq.sv
module mon_chan_seq #(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [CH_W-1:0] cur_ch_i,
  input  logic [CH_W-1:0] sel_i,
  input  logic            diff_i,
  output logic [CH_W-1:0] next_ch_o,
  output logic            last_o
);
  logic [CH_W:0] sum;
  always_comb begin
    sum       = {1'b0, cur_ch_i} + (diff_i ? (CH_W+1)'(2) : (CH_W+1)'(1));
    next_ch_o = sum[CH_W-1:0];
    last_o    = sum > {1'b0, sel_i};
  end
endmodule

// File: rtl/mon_thr_bank.sv
module mon_thr_bank #(
  parameter int NUM_CH = 4,
  parameter int THR_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       wr_i,
  input  logic [THR_W-1:0]        lo_i,
  input  logic [THR_W-1:0]        hi_i,
  output logic [NUM_CH*THR_W-1:0] lo_o,
  output logic [NUM_CH*THR_W-1:0] hi_o,
  output logic [NUM_CH-1:0]       we_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [THR_W-1:0] lo_q, hi_q;
    logic             we_q;
    // reset value disables the channel (full unipolar window)
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '1;
        we_q <= 1'b0;
      end else begin
        we_q <= wr_i[i];
        if (wr_i[i]) begin
          lo_q <= lo_i;
          hi_q <= hi_i;
        end
      end
    end
    assign lo_o[i*THR_W +: THR_W] = lo_q;
    assign hi_o[i*THR_W +: THR_W] = hi_q;
    assign we_o[i]                = we_q;
  end
endmodule

// File: rtl/mon_setup_loader.sv
module mon_setup_loader
  import mon_setup_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int THR_W   = 12,
  parameter int BYTE_W  = 8,
  parameter int DELAY_W = 3,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_start_i,
  input  logic                    byte_valid_i,
  input  logic [BYTE_W-1:0]       byte_data_i,
  input  logic [CH_W-1:0]         chan_sel_i,
  input  logic                    diff_mode_i,
  output logic [DELAY_W-1:0]      delay_code_o,
  output logic                    int_en_o,
  output logic [NUM_CH-1:0]       alarm_clr_o,
  output logic [NUM_CH*THR_W-1:0] lo_thr_o,
  output logic [NUM_CH*THR_W-1:0] hi_thr_o,
  output logic [NUM_CH-1:0]       thr_we_o,
  output logic                    overrun_o
);
  localparam int WORD_W = 2 * THR_W;
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam int SHR_W  = (NBYTES - 1) * BYTE_W;
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(NBYTES - 1);

  ld_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CH_W-1:0]   cur_ch_q, sel_q;
  logic              diff_q;
  logic [SHR_W-1:0]  shr_q;
  logic [DELAY_W-1:0] delay_q;
  logic              int_en_q, ovr_q;
  logic [NUM_CH-1:0] clr_q;

  logic acc_setup, acc_thr, acc_ovr, word_done;
  logic [NUM_CH-1:0]  dec_clr, wr_mask;
  logic [DELAY_W-1:0] dec_delay;
  logic               dec_int_en;
  logic [CH_W-1:0]    next_ch;
  logic               last_ch;
  logic [WORD_W-1:0]  word;

  // a frame start always wins over the running frame
  assign acc_setup = byte_valid_i && (frame_start_i || state_q == ST_SETUP);
  assign acc_thr   = byte_valid_i && !frame_start_i && state_q == ST_THR;
  assign acc_ovr   = byte_valid_i && !frame_start_i && state_q == ST_DONE;
  assign word_done = acc_thr && cnt_q == LAST_BYTE;
  assign word      = {shr_q, byte_data_i};

  mon_setup_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .DELAY_W(DELAY_W)) u_dec (
    .byte_i     (byte_data_i),
    .clr_mask_o (dec_clr),
    .delay_o    (dec_delay),
    .int_en_o   (dec_int_en)
  );

  mon_chan_seq #(.NUM_CH(NUM_CH)) u_seq (
    .cur_ch_i  (cur_ch_q),
    .sel_i     (sel_q),
    .diff_i    (diff_q),
    .next_ch_o (next_ch),
    .last_o    (last_ch)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    localparam int PREV = (i > 0) ? i - 1 : 0;
    localparam bit ODD  = (i % 2) == 1;
    assign wr_mask[i] = word_done &&
                        ((cur_ch_q == CH_W'(i)) ||
                         (ODD && diff_q && cur_ch_q == CH_W'(PREV)));
  end

  mon_thr_bank #(.NUM_CH(NUM_CH), .THR_W(THR_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_mask),
    .lo_i   (word[WORD_W-1 -: THR_W]),
    .hi_i   (word[THR_W-1:0]),
    .lo_o   (lo_thr_o),
    .hi_o   (hi_thr_o),
    .we_o   (thr_we_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_SETUP;
      cnt_q    <= '0;
      cur_ch_q <= '0;
      sel_q    <= '0;
      diff_q   <= 1'b0;
      shr_q    <= '0;
    end else if (acc_setup) begin
      state_q  <= ST_THR;
      cnt_q    <= '0;
      cur_ch_q <= '0;
      sel_q    <= chan_sel_i;
      diff_q   <= diff_mode_i;
    end else if (frame_start_i) begin
      state_q <= ST_SETUP;
      cnt_q   <= '0;
    end else if (acc_thr) begin
      if (word_done) begin
        cnt_q <= '0;
        if (last_ch) state_q  <= ST_DONE;
        else         cur_ch_q <= next_ch;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        shr_q <= (SHR_W > BYTE_W) ? {shr_q[SHR_W-BYTE_W-1:0], byte_data_i}
                                  : SHR_W'(byte_data_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_q  <= '0;
      int_en_q <= 1'b0;
      clr_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      clr_q <= acc_setup ? dec_clr : '0;
      if (acc_setup) begin
        delay_q  <= dec_delay;
        int_en_q <= dec_int_en;
      end
      if (frame_start_i) ovr_q <= 1'b0;
      else if (acc_ovr)  ovr_q <= 1'b1;
    end
  end

  assign delay_code_o = delay_q;
  assign int_en_o     = int_en_q;
  assign alarm_clr_o  = clr_q;
  assign overrun_o    = ovr_q;
endmodule

// File: rtl/mon_setup_loader_chk.sv
module mon_setup_loader_chk #(
  parameter int NUM_CH  = 4,
  parameter int THR_W   = 12,
  parameter int BYTE_W  = 8,
  parameter int DELAY_W = 3,
  parameter int CH_W    = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    frame_start_i,
  input logic                    byte_valid_i,
  input logic [BYTE_W-1:0]       byte_data_i,
  input logic [CH_W-1:0]         chan_sel_i,
  input logic                    diff_mode_i,
  input logic [DELAY_W-1:0]      delay_code_o,
  input logic                    int_en_o,
  input logic [NUM_CH-1:0]       alarm_clr_o,
  input logic [NUM_CH*THR_W-1:0] lo_thr_o,
  input logic [NUM_CH*THR_W-1:0] hi_thr_o,
  input logic [NUM_CH-1:0]       thr_we_o,
  input logic                    overrun_o
);
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> ($stable(delay_code_o) && $stable(int_en_o)));

  // R3
  clr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_clr_o != '0) |-> $past(byte_valid_i));

  // R5
  we_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_we_o != '0) |-> $past(byte_valid_i && !frame_start_i));

  // R5
  thr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_we_o == '0) |-> ($stable(lo_thr_o) && $stable(hi_thr_o)));

  // R7
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_we_o != '0) |-> ($countones(thr_we_o) <= 2));

  // R8
  fs_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (thr_we_o == '0 && !overrun_o));

  // R9
  ovr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(byte_valid_i));
endmodule

bind mon_setup_loader mon_setup_loader_chk #(
  .NUM_CH(NUM_CH), .THR_W(THR_W), .BYTE_W(BYTE_W), .DELAY_W(DELAY_W), .CH_W(CH_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .byte_valid_i (byte_valid_i),
  .byte_data_i  (byte_data_i),
  .chan_sel_i   (chan_sel_i),
  .diff_mode_i  (diff_mode_i),
  .delay_code_o (delay_code_o),
  .int_en_o     (int_en_o),
  .alarm_clr_o  (alarm_clr_o),
  .lo_thr_o     (lo_thr_o),
  .hi_thr_o     (hi_thr_o),
  .thr_we_o     (thr_we_o),
  .overrun_o    (overrun_o)
);

// File: tb/tb_mon_setup_loader.sv
`timescale 1ns/1ps
module tb_mon_setup_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0, bv = 1'b0, diff = 1'b0;
  logic [7:0]  bd = '0;
  logic [1:0]  sel = '0;
  logic [2:0]  delay;
  logic        int_en, ovr;
  logic [3:0]  clr, we;
  logic [47:0] lo, hi;

  logic [3:0]  cap_clr, cap_we;
  logic [11:0] exp_lo [4];
  logic [11:0] exp_hi [4];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mon_setup_loader dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .byte_valid_i(bv),
    .byte_data_i(bd), .chan_sel_i(sel), .diff_mode_i(diff),
    .delay_code_o(delay), .int_en_o(int_en), .alarm_clr_o(clr),
    .lo_thr_o(lo), .hi_thr_o(hi), .thr_we_o(we), .overrun_o(ovr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic f);
    @(negedge clk);
    bv = 1'b1; bd = d; fs = f;
    @(negedge clk);
    bv = 1'b0; fs = 1'b0;
    cap_clr = clr; cap_we = we;
  endtask

  task automatic fs_only();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
    cap_we = we;
  endtask

  task automatic send_thr(input string req, input logic [11:0] l, input logic [11:0] h,
                          input logic [3:0] we_exp);
    send(l[11:4], 1'b0);            check({req, " byte0 no strobe"}, cap_we, 0);
    send({l[3:0], h[11:8]}, 1'b0);  check({req, " byte1 no strobe"}, cap_we, 0);
    send(h[7:0], 1'b0);             check({req, " byte2 strobe"}, cap_we, we_exp);
    for (int c = 0; c < 4; c++)
      if (we_exp[c]) begin exp_lo[c] = l; exp_hi[c] = h; end
  endtask

  task automatic check_regs(input string req);
    for (int c = 0; c < 4; c++) begin
      check({req, " lower"}, lo[c*12 +: 12], exp_lo[c]);
      check({req, " upper"}, hi[c*12 +: 12], exp_hi[c]);
    end
  endtask

  task automatic t_reset();
    for (int c = 0; c < 4; c++) begin exp_lo[c] = 12'h000; exp_hi[c] = 12'hFFF; end
    check("R1 delay", delay, 0); check("R1 int_en", int_en, 0);
    check("R1 clr", clr, 0); check("R1 we", we, 0); check("R1 overrun", ovr, 0);
    check_regs("R1");
  endtask

  task automatic t_setup();
    sel = 2'd0; diff = 1'b0;
    send(8'hA7, 1'b1);
    check("R3 clr pulse ch0,ch2", cap_clr, 4'b0101);
    check("R2 delay", delay, 3'd3); check("R2 int_en", int_en, 1);
    @(negedge clk);
    check("R3 clr one cycle", clr, 0);
    check("R2 delay held", delay, 3'd3);
  endtask

  task automatic t_single();
    sel = 2'd3; diff = 1'b0;
    send(8'h00, 1'b1);
    check("R3 no clr", cap_clr, 0);
    check("R2 delay cleared", delay, 0); check("R2 int_en cleared", int_en, 0);
    sel = 2'd0; // R6: ignored until next setup byte
    send_thr("R4 R5 ch0", 12'h123, 12'hABC, 4'b0001);
    send_thr("R6 ch1", 12'h456, 12'hDEF, 4'b0010);
    send_thr("R6 ch2", 12'h010, 12'hF0E, 4'b0100);
    send_thr("R6 ch3", 12'h7A5, 12'h8C3, 4'b1000);
    check_regs("R4 single-ended");
    check("R6 no overrun yet", ovr, 0);
  endtask

  task automatic t_sel_limit();
    sel = 2'd1; diff = 1'b0;
    send(8'h00, 1'b1);
    send_thr("R6 sel1 ch0", 12'h111, 12'h222, 4'b0001);
    send_thr("R6 sel1 ch1", 12'h333, 12'h444, 4'b0010);
    check("R9 not yet", ovr, 0);
    send(8'h55, 1'b0);
    check("R9 surplus no strobe", cap_we, 0);
    check("R9 overrun set", ovr, 1);
    send(8'h66, 1'b0);
    check("R9 overrun sticky", ovr, 1);
    check_regs("R9 regs untouched");
  endtask

  task automatic t_diff();
    sel = 2'd3; diff = 1'b1;
    send(8'h00, 1'b1);
    check("R8 overrun cleared", ovr, 0);
    send_thr("R7 pair0", 12'h0A0, 12'h0B0, 4'b0011);
    send_thr("R7 pair2", 12'h0C0, 12'h0D0, 4'b1100);
    send(8'h77, 1'b0);
    check("R7 end after pair2", ovr, 1);
    check_regs("R7 sel3");
    sel = 2'd1;
    send(8'h00, 1'b1);
    send_thr("R7 sel1 pair0", 12'h3C3, 12'hC3C, 4'b0011);
    send(8'h12, 1'b0);
    check("R7 sel1 single pair", ovr, 1);
    check("R7 sel1 no strobe", cap_we, 0);
    check_regs("R7 sel1");
  endtask

  task automatic t_abort();
    sel = 2'd0; diff = 1'b0;
    send(8'h00, 1'b1);
    send(8'hFF, 1'b0); send(8'hFF, 1'b0);
    fs_only();
    check("R8 fs no strobe", cap_we, 0);
    check("R8 fs clears overrun", ovr, 0);
    send(8'h00, 1'b0); // setup byte after bare frame start
    send_thr("R8 realigned", 12'h246, 12'h9BD, 4'b0001);
    check_regs("R8 partial discarded");
  endtask

  task automatic t_same_cycle();
    sel = 2'd3; diff = 1'b0;
    send(8'h00, 1'b1);
    send(8'h99, 1'b0);
    send(8'h5E, 1'b1);
    check("R10 clr ch1,ch3", cap_clr, 4'b1010);
    check("R10 no strobe", cap_we, 0);
    check("R10 delay", delay, 3'd7); check("R10 int_en", int_en, 0);
    send_thr("R10 ch0 fresh", 12'h5A5, 12'hA5A, 4'b0001);
    check_regs("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_single();
    t_sel_limit();
    t_diff();
    t_abort();
    t_same_cycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule